// File: doc/BRIEF.md
# Virtual Error Barrier Deferral Unit

This block performs the barrier step for a virtual asynchronous error that a hypervisor has injected into a guest. Each cycle in which the execute input pulses, the unit decides whether a virtual error is both armed and blocked from being taken. An error is armed when the hypervisor's routing bits allow virtual errors and the injection bit is set. It is blocked when the guest masks aborts, the core is halted, or external debug has shut off interrupts for level 1. When both hold, the unit stores a 64-bit deferred record built from the hypervisor-supplied 25-bit syndrome and drops the injection bit, so the error is reported through the record instead of being taken.

The injection bit lives inside the unit. Software raises it through a set strobe and reads it back on an output. The barrier is only meaningful while level 2 is enabled and the core runs at level 0 or 1. An execute pulse outside those conditions raises a one-cycle flag and changes nothing. All updates are registered, and a synchronous reset clears the record, the injection bit and the flag.

Top module: `vserr_defer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_o`, `record_o` and `illegal_o` become 0 after that edge.
- R2: `pend_set_i` high at an edge sets `pend_o` to 1 after that edge, unless R4's clear occurs in the same cycle.
- R3: On a firing execute, `record_o` becomes, after the same edge, bit 31 = 1, bits 24:0 = `syndrome_i` (bit 24 copied from syndrome bit 24, bits 23:0 from syndrome bits 23:0), and all other bits 0. An execute fires when all of these hold: `exec_i` = 1, `el2_en_i` = 1, `cur_lvl_i` is 0 or 1, `trap_gen_i` = 0, `abort_route_i` = 1, `pend_o` = 1, and the error is masked (R5).
- R4: A firing execute clears `pend_o` to 0 after the same edge, and this clear wins over a `pend_set_i` in the same cycle.
- R5: The error is masked when `halted_i`, `dbg_intdis_i` or `abort_mask_i` is 1. An otherwise eligible execute that is not masked leaves `record_o` and `pend_o` unchanged.
- R6: When `trap_gen_i` = 1 or `abort_route_i` = 0, an execute leaves `record_o` and `pend_o` unchanged.
- R7: When `pend_o` = 0, an execute leaves `record_o` unchanged and `pend_o` at 0.
- R8: An execute with `el2_en_i` = 0, or with `cur_lvl_i` equal to 2 or 3, drives `illegal_o` to 1 for the cycle after that edge and leaves `record_o` unchanged. It does not clear `pend_o`. A `pend_set_i` in the same cycle still takes effect.
- R9: `illegal_o` is 0 after any edge at which no out-of-context execute was sampled.
- R10: `record_o` holds its value until the next firing execute or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Barrier execute pulse |
| el2_en_i | input | 1 | Level 2 is enabled |
| cur_lvl_i | input | 2 | Current exception level (0..3) |
| trap_gen_i | input | 1 | Hypervisor trap-general control bit |
| abort_route_i | input | 1 | Hypervisor abort routing bit |
| abort_mask_i | input | 1 | Guest abort mask bit |
| halted_i | input | 1 | Core is halted in debug |
| dbg_intdis_i | input | 1 | External debug disables interrupts for level 1 |
| syndrome_i | input | 25 | Hypervisor-supplied virtual error syndrome |
| pend_set_i | input | 1 | Software strobe that sets the injection bit |
| pend_o | output | 1 | Virtual error injection (pending) bit |
| record_o | output | 64 | Deferred error record |
| illegal_o | output | 1 | Out-of-context execute flag, one cycle |

## Verification
The bench builds the unit with its default parameters: a 25-bit syndrome, a 64-bit record with the flag at bit 31, and a 2-bit level field. Every record bit therefore exists and can be checked. The syndrome's top bit (24), the zero gap from 25 to 30 and the zero upper word can all be seen on the port, and all four levels can be driven, so both out-of-range levels 2 and 3 are tested alongside level 2 being disabled. Each of the three mask sources is also tested alone.

// File: rtl/vdefer_pkg.sv
package vdefer_pkg;

   // Outcome of one qualification pass
   typedef struct packed {
      logic enabled;   // routing allows virtual errors
      logic pending;   // enabled and injection bit set
      logic masked;    // error cannot be taken now
      logic legal;     // execute arrived in a valid context
      logic fire;      // defer now: write record, drop injection bit
      logic illegal;   // execute arrived out of context
   } vq_t;

endpackage

// File: rtl/vdefer_qualify.sv
module vdefer_qualify
   import vdefer_pkg::*;
#(
   parameter int LVL_W     = 2,
   parameter int GUEST_TOP = 1
) (
   input  logic             exec,
   input  logic             el2_en,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic             trap_gen,
   input  logic             abort_route,
   input  logic             abort_mask,
   input  logic             halted,
   input  logic             dbg_intdis,
   input  logic             pend_bit,
   output vq_t              q
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(GUEST_TOP);

   if (LVL_W < 2) begin : g_bad_lvl
      $error("LVL_W must hold levels 0..3");
   end
   if (GUEST_TOP >= (1 << LVL_W)) begin : g_bad_top
      $error("GUEST_TOP out of range for LVL_W");
   end

   logic in_guest;

   always_comb begin
      in_guest  = (cur_lvl <= TOP_LVL);
      q.enabled = !trap_gen && abort_route;
      q.pending = q.enabled && pend_bit;
      q.masked  = halted || dbg_intdis || abort_mask;
      q.legal   = el2_en && in_guest;
      q.fire    = exec && q.legal && q.pending && q.masked;
      q.illegal = exec && !q.legal;
   end

endmodule

// File: rtl/vdefer_record.sv
module vdefer_record #(
   parameter int SYN_W    = 25,
   parameter int REC_W    = 64,
   parameter int FLAG_BIT = 31
) (
   input  logic [SYN_W-1:0] syn,
   output logic [REC_W-1:0] rec
);
   if (FLAG_BIT >= REC_W) begin : g_bad_flag
      $error("FLAG_BIT must lie inside the record");
   end
   if (SYN_W > FLAG_BIT) begin : g_bad_syn
      $error("syndrome must end below FLAG_BIT");
   end

   for (genvar b = 0; b < REC_W; b++) begin : g_bit
      if (b < SYN_W) begin : g_syn
         assign rec[b] = syn[b];
      end else if (b == FLAG_BIT) begin : g_flag
         assign rec[b] = 1'b1;
      end else begin : g_zero
         assign rec[b] = 1'b0;
      end
   end

endmodule

// File: rtl/vdefer_state.sv
module vdefer_state #(
   parameter int REC_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire,
   input  logic             illegal_in,
   input  logic             pend_set,
   input  logic [REC_W-1:0] rec_new,
   output logic             pend_q,
   output logic [REC_W-1:0] rec_q,
   output logic             illegal_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q    <= 1'b0;
         rec_q     <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= illegal_in;
         if (fire) begin
            pend_q <= 1'b0;
            rec_q  <= rec_new;
         end else if (pend_set) begin
            pend_q <= 1'b1;
         end
      end
   end

   // R2: a set with no clear makes the bit 1
   assert_set_takes_R2: assert property (@(posedge clk) disable iff (rst)
      (pend_set && !fire) |=> pend_q);

   // R7: with no set and no clear, a low bit stays low
   assert_pend_stays_low_R7: assert property (@(posedge clk) disable iff (rst)
      (!pend_q && !pend_set) |=> !pend_q);

   // R10: the record only moves on a fire
   assert_record_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(rec_q));

endmodule

// File: rtl/vserr_defer_unit.sv
module vserr_defer_unit
   import vdefer_pkg::*;
#(
   parameter int SYN_W     = 25,
   parameter int REC_W     = 64,
   parameter int FLAG_BIT  = 31,
   parameter int LVL_W     = 2,
   parameter int GUEST_TOP = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             exec_i,
   input  logic             el2_en_i,
   input  logic [LVL_W-1:0] cur_lvl_i,
   input  logic             trap_gen_i,
   input  logic             abort_route_i,
   input  logic             abort_mask_i,
   input  logic             halted_i,
   input  logic             dbg_intdis_i,
   input  logic [SYN_W-1:0] syndrome_i,
   input  logic             pend_set_i,
   output logic             pend_o,
   output logic [REC_W-1:0] record_o,
   output logic             illegal_o
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(GUEST_TOP);

   vq_t              qual;
   logic [REC_W-1:0] rec_built;

   vdefer_qualify #(.LVL_W(LVL_W), .GUEST_TOP(GUEST_TOP)) u_qual (
      .exec        (exec_i),
      .el2_en      (el2_en_i),
      .cur_lvl     (cur_lvl_i),
      .trap_gen    (trap_gen_i),
      .abort_route (abort_route_i),
      .abort_mask  (abort_mask_i),
      .halted      (halted_i),
      .dbg_intdis  (dbg_intdis_i),
      .pend_bit    (pend_o),
      .q           (qual)
   );

   vdefer_record #(.SYN_W(SYN_W), .REC_W(REC_W), .FLAG_BIT(FLAG_BIT)) u_rec (
      .syn (syndrome_i),
      .rec (rec_built)
   );

   vdefer_state #(.REC_W(REC_W)) u_state (
      .clk        (clk),
      .rst        (rst),
      .fire       (qual.fire),
      .illegal_in (qual.illegal),
      .pend_set   (pend_set_i),
      .rec_new    (rec_built),
      .pend_q     (pend_o),
      .rec_q      (record_o),
      .illegal_q  (illegal_o)
   );

   // R3: an eligible, masked execute leaves the syndrome and flag in the record
   assert_record_write_R3: assert property (@(posedge clk) disable iff (rst)
      (exec_i && el2_en_i && cur_lvl_i <= TOP_LVL && !trap_gen_i && abort_route_i
       && pend_o && (halted_i || dbg_intdis_i || abort_mask_i))
      |=> (record_o[FLAG_BIT] && record_o[SYN_W-1:0] == $past(syndrome_i)));

   // R4: the same execute drops the injection bit, even against a set
   assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
      (exec_i && el2_en_i && cur_lvl_i <= TOP_LVL && qual.enabled && pend_o
       && qual.masked) |=> !pend_o);

   // R5: an unmasked error never changes the record
   assert_unmasked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (exec_i && !qual.masked) |=> $stable(record_o));

   // R6: routing that disables virtual errors never changes the record
   assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (exec_i && !qual.pending) |=> $stable(record_o));

   // R8: an out-of-context execute flags and leaves the record alone
   assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (rst)
      (exec_i && (!el2_en_i || cur_lvl_i > TOP_LVL))
      |=> (illegal_o && $stable(record_o)));

   // R9: no flag without an out-of-context execute
   assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !(exec_i && !qual.legal) |=> !illegal_o);

endmodule

// File: tb/tb_vserr_defer_unit.sv
module tb_vserr_defer_unit;
   localparam int CLK_PERIOD = 10;
   localparam int SYN_W = 25;
   localparam int REC_W = 64;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             exec_i = 1'b0;
   logic             el2_en_i = 1'b0;
   logic [1:0]       cur_lvl_i = 2'd0;
   logic             trap_gen_i = 1'b0;
   logic             abort_route_i = 1'b0;
   logic             abort_mask_i = 1'b0;
   logic             halted_i = 1'b0;
   logic             dbg_intdis_i = 1'b0;
   logic [SYN_W-1:0] syndrome_i = '0;
   logic             pend_set_i = 1'b0;
   logic             pend_o;
   logic [REC_W-1:0] record_o;
   logic             illegal_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vserr_defer_unit dut (
      .clk(clk), .rst(rst), .exec_i(exec_i), .el2_en_i(el2_en_i),
      .cur_lvl_i(cur_lvl_i), .trap_gen_i(trap_gen_i),
      .abort_route_i(abort_route_i), .abort_mask_i(abort_mask_i),
      .halted_i(halted_i), .dbg_intdis_i(dbg_intdis_i),
      .syndrome_i(syndrome_i), .pend_set_i(pend_set_i),
      .pend_o(pend_o), .record_o(record_o), .illegal_o(illegal_o)
   );

   typedef struct packed {
      logic        pset;
      logic        el2;
      logic [1:0]  lvl;
      logic        tg;
      logic        ar;
      logic        am;
      logic        hlt;
      logic        dbg;
      logic [24:0] syn;
      logic        fire;
      logic        ill;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,25'h1ABCDEF,1'b1,1'b0}, // R3 abort mask
      '{1'b1,1'b1,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,25'h0123456,1'b1,1'b0}, // R5 halted
      '{1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,25'h1000001,1'b1,1'b0}, // R5 debug off
      '{1'b1,1'b1,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,25'h0FFFFFF,1'b0,1'b0}, // R5 unmasked
      '{1'b1,1'b1,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,25'h1555555,1'b0,1'b0}, // R6 trap set
      '{1'b1,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,25'h0AAAAAA,1'b0,1'b0}, // R6 no route
      '{1'b0,1'b1,2'd0,1'b0,1'b1,1'b1,1'b1,1'b1,25'h1234567,1'b0,1'b0}, // R7 not pending
      '{1'b1,1'b0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,25'h0000F0F,1'b0,1'b1}, // R8 el2 off
      '{1'b1,1'b1,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,25'h0000F0F,1'b0,1'b1}, // R8 level 2
      '{1'b1,1'b1,2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,25'h0000F0F,1'b0,1'b1}, // R8 level 3
      '{1'b1,1'b1,2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,25'h0000000,1'b1,1'b0}  // R3 zero syndrome
   };

   function automatic logic [REC_W-1:0] rec_of(input logic [SYN_W-1:0] s);
      logic [REC_W-1:0] r;
      r = '0;
      r[31] = 1'b1;
      r[24] = s[24];
      r[23:0] = s[23:0];
      return r;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic chkr(input string req, input logic [REC_W-1:0] act,
                       input logic [REC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; exec_i = 1'b0; pend_set_i = 1'b0;
      tick(); tick();
      rst = 1'b0;
   endtask

   task automatic drive(input vec_t v);
      el2_en_i = v.el2; cur_lvl_i = v.lvl; trap_gen_i = v.tg;
      abort_route_i = v.ar; abort_mask_i = v.am; halted_i = v.hlt;
      dbg_intdis_i = v.dbg; syndrome_i = v.syn;
   endtask

   initial begin
      #(CLK_PERIOD * 3000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [REC_W-1:0] first_rec;
      #1;
      do_reset();
      // R1: reset state
      chk1("R1 pend", pend_o, 1'b0);
      chkr("R1 record", record_o, '0);
      chk1("R1 flag", illegal_o, 1'b0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         do_reset();
         if (VECS[i].pset) begin
            pend_set_i = 1'b1;
            tick();
            pend_set_i = 1'b0;
            chk1("R2 set", pend_o, 1'b1);
         end
         drive(VECS[i]);
         exec_i = 1'b1;
         tick();
         exec_i = 1'b0;
         chk1(VECS[i].fire ? "R4 pend cleared" : "R5/R6/R7/R8 pend kept",
              pend_o, VECS[i].pset && !VECS[i].fire);
         chkr(VECS[i].fire ? "R3 record" : "R5/R6/R7/R8 record kept",
              record_o, VECS[i].fire ? rec_of(VECS[i].syn) : '0);
         chk1(VECS[i].ill ? "R8 flag" : "R9 flag low", illegal_o, VECS[i].ill);
         tick();
         chk1("R8/R9 flag one cycle", illegal_o, 1'b0);
      end

      // R4: clear beats a set in the same cycle
      do_reset();
      pend_set_i = 1'b1; tick();
      drive('{1'b1,1'b1,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,25'h1F0F0F0,1'b1,1'b0});
      exec_i = 1'b1; tick();
      exec_i = 1'b0; pend_set_i = 1'b0;
      chk1("R4 clear wins", pend_o, 1'b0);
      first_rec = rec_of(25'h1F0F0F0);
      chkr("R3 record with set", record_o, first_rec);

      // R10: record holds through non-firing executes and idle cycles
      pend_set_i = 1'b1; tick(); pend_set_i = 1'b0;
      syndrome_i = 25'h0000ABC; abort_mask_i = 1'b0;
      exec_i = 1'b1; tick(); exec_i = 1'b0;
      tick(); tick();
      chkr("R10 record held", record_o, first_rec);
      chk1("R5 pend kept unmasked", pend_o, 1'b1);
      abort_mask_i = 1'b1; exec_i = 1'b1; tick(); exec_i = 1'b0;
      chkr("R10 record replaced", record_o, rec_of(25'h0000ABC));

      // R8: set still lands during an out-of-context execute
      do_reset();
      drive('{1'b0,1'b1,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,25'h1111111,1'b0,1'b1});
      pend_set_i = 1'b1; exec_i = 1'b1; tick();
      pend_set_i = 1'b0; exec_i = 1'b0;
      chk1("R8 set during illegal", pend_o, 1'b1);
      chk1("R8 flag with set", illegal_o, 1'b1);
      chkr("R8 record untouched", record_o, '0);

      // R1: reset clears a live pending bit and record
      cur_lvl_i = 2'd0; exec_i = 1'b1; tick(); exec_i = 1'b0;
      chkr("R3 fire before reset", record_o, rec_of(25'h1111111));
      rst = 1'b1; pend_set_i = 1'b1; tick(); rst = 1'b0; pend_set_i = 1'b0;
      chk1("R1 pend after reset", pend_o, 1'b0);
      chkr("R1 record after reset", record_o, '0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule